// File: doc/BRIEF.md
# SMBus Register Slave with Bus-Stuck Timeout

This block is a synchronous two-wire bus slave that serves a small bank of 8-bit registers. It takes already-synchronized copies of the clock and data lines and runs on the system clock. It drives only an open-drain pull-down enable for the data line. It recognises bus START and STOP conditions, including a repeated START. It answers its own 7-bit address, which is given as an input. It also answers a broadcast write address and the alert response address.

A host writes a register with an address-write byte, a command byte that selects the register and one data byte. A second data byte is acknowledged but has no effect. A host reads by sending the command byte, a repeated START and an address-read byte. The slave then returns the selected register, and then the registers after it for as long as the host acknowledges. This covers the byte and word forms of read and write. A command code that names no register is refused.

When the external alert input is raised, the block can identify itself through the alert response query. If either bus line is held low for too long, the interface returns to idle and lets go of the data line. The limit is a parameter counted in system clock cycles.

Top module: `smb_regslave`

## Requirements
- R1: After reset, `sda_oe` is 0 and the registers hold their reset values. Register 0 is the control register and resets to 0x10. Every other register resets to 0x00.
- R2: A START (data falling while clock is high) begins an address phase from any state, including a repeated START in mid-transaction. A STOP (data rising while clock is high) returns the slave to idle with `sda_oe` at 0.
- R3: An address byte whose upper seven bits do not match `dev_addr`, and that is neither the broadcast nor an accepted alert response, is not acknowledged. `sda_oe` then stays 0 until the next START, whatever bytes follow.
- R4: Write transfer: address byte `{dev_addr,0}`, then command byte c, then data byte d. Each byte is acknowledged, and register c then holds d.
- R5: In a write transfer, every data byte after the first is acknowledged and is written to no register.
- R6: Read transfer: address byte `{dev_addr,0}` and command byte c, then a repeated START and address byte `{dev_addr,1}`. The slave returns register c, most significant bit first.
- R7: While the host acknowledges, each further byte read is the next register, (c+n) mod NREG, so a two-byte read returns registers c and c+1.
- R8: A command byte of value NREG or above (NREG = 4 by default) is not acknowledged, and no register changes.
- R9: Address byte 0xC6 is accepted as a write to all devices, whatever `dev_addr` is, while bit 4 of the control register is 1. While that bit is 0, the byte is not acknowledged.
- R10: Address byte 0x19 (7-bit address 0001100, read) is acknowledged only when `alert_i` is 1 and an alert is pending. A rising edge of `alert_i` makes an alert pending. The slave returns `{dev_addr,0}`, and the pending alert is then cleared. A further query is not acknowledged until `alert_i` rises again.
- R11: If either line stays low for TMO_CYC consecutive clock cycles, the slave goes to idle with `sda_oe` at 0, and a later transaction is served normally.
- R12: `sda_oe` rises only while the bus clock is low, and is stable while the bus clock is high during data and acknowledge bits. Incoming bits are taken at the rising edge of the bus clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized bus clock line |
| sda_i | input | 1 | Synchronized bus data line |
| dev_addr | input | 7 | Own 7-bit bus address |
| alert_i | input | 1 | Alert request, active high |
| sda_oe | output | 1 | 1 pulls the data line low |

## Verification
The stuck-bus timer and the byte engine can both act on `sda_oe` in the same cycle. This happens when the timeout expires while the slave is holding an acknowledge low. The bench provokes it by freezing the bus clock low right after an address byte the slave accepts. It checks that the pull-down is present at first, that it drops once the limit has passed, and that a following read returns the right value. A second overlap is a rising `alert_i` and an alert response read. The bench checks the acknowledge and the returned address, and then checks that a second query is refused.

// File: rtl/smb_pkg.sv
package smb_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_RXACK,
        S_ACKHOLD,
        S_TXLOAD,
        S_TX,
        S_TXACK,
        S_IGNORE
    } smb_st_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_CMD,
        PH_DATA
    } smb_ph_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    localparam logic [6:0] ARA_ADDR  = 7'h0C;
    localparam logic [7:0] BCAST_WR  = 8'hC6;
    localparam int         MWE_BIT   = 4;

    // (base + ofs) reduced into 0..n-1, ofs < n assumed
    function automatic int unsigned wrap_idx(int unsigned base, int unsigned ofs, int unsigned n);
        int unsigned s;
        s = base + ofs;
        return (s >= n) ? s - n : s;
    endfunction

endpackage

// File: rtl/smb_bus_cond.sv
module smb_bus_cond
    import smb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        ev.start = scl_q & scl_i & sda_q & ~sda_i;
        ev.stop  = scl_q & scl_i & ~sda_q & sda_i;
        ev.rise  = ~scl_q & scl_i;
        ev.fall  = scl_q & ~scl_i;
    end

    // R2: a condition is never reported together with a clock edge
    p_cond_excl_r2: assert property (@(posedge clk) disable iff (rst)
        (ev.start || ev.stop) |-> !(ev.rise || ev.fall));

endmodule

// File: rtl/smb_stuck_timer.sv
module smb_stuck_timer #(
    parameter int TMO_CYC = 2_500_000
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic tmo
);
    localparam int CW = $clog2(TMO_CYC + 1);

    logic [CW-1:0] cnt;
    logic          low;

    assign low = !scl_i || !sda_i;
    assign tmo = low && (cnt == CW'(TMO_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || !low || tmo) cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end

    p_cnt_bound_r11: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) < TMO_CYC);

    p_tmo_low_before_r11: assert property (@(posedge clk) disable iff (rst)
        tmo |-> $past(!scl_i || !sda_i));

endmodule

// File: rtl/smb_regbank.sv
module smb_regbank
    import smb_pkg::*;
#(
    parameter int         NREG     = 4,
    parameter int         CTRL_IDX = 0,
    parameter logic [7:0] CTRL_RST = 8'h10,
    localparam int        IW       = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [7:0]    wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [7:0]    rd_data,
    output logic          mw_en
);
    logic [7:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [7:0] RV = (g == CTRL_IDX) ? CTRL_RST : 8'h00;
        always_ff @(posedge clk) begin
            if (rst)                                   regs[g] <= RV;
            else if (wr_en && wr_idx == IW'(g))        regs[g] <= wr_data;
        end

        // R5/R8: a register moves only when a write selects it
        p_reg_hold_r8: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && wr_idx == IW'(g)) |=> $stable(regs[g]));
    end

    assign rd_data = regs[rd_idx];
    assign mw_en   = regs[CTRL_IDX][MWE_BIT];

endmodule

// File: rtl/smb_regslave.sv
module smb_regslave
    import smb_pkg::*;
#(
    parameter int         NREG     = 4,
    parameter int         CTRL_IDX = 0,
    parameter logic [7:0] CTRL_RST = 8'h10,
    parameter int         TMO_CYC  = 2_500_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [6:0] dev_addr,
    input  logic       alert_i,
    output logic       sda_oe
);
    localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

    bus_ev_t       ev;
    logic          tmo;
    smb_st_e       st;
    smb_ph_e       ph, dec_ph;
    logic [6:0]    shreg;
    logic [7:0]    rxb, tx_byte, rd_data;
    logic [3:0]    bitcnt;
    logic          ack_q, txm, ara_q, wr_done, oe_q, mack_q;
    logic [IW-1:0] cmd, tx_ofs, rd_idx;
    logic          dec_ack, dec_rd, dec_ara, dec_wr, dec_fire, wr_en, mw_en;
    logic          alert_q, alert_pend, ara_done, ctl_ok;

    smb_bus_cond u_cond (.clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev(ev));

    smb_stuck_timer #(.TMO_CYC(TMO_CYC)) u_tmr (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .tmo(tmo));

    smb_regbank #(.NREG(NREG), .CTRL_IDX(CTRL_IDX), .CTRL_RST(CTRL_RST)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(cmd), .wr_data(rxb),
        .rd_idx(rd_idx), .rd_data(rd_data), .mw_en(mw_en));

    assign rxb     = {shreg, sda_i};
    assign rd_idx  = IW'(wrap_idx(int'(cmd), int'(tx_ofs), NREG));
    assign tx_byte = ara_q ? {dev_addr, 1'b0} : rd_data;
    assign ctl_ok  = !tmo && !ev.start && !ev.stop;

    // byte decision at the eighth rising clock edge
    always_comb begin
        dec_ack = 1'b0;
        dec_rd  = 1'b0;
        dec_ara = 1'b0;
        dec_wr  = 1'b0;
        dec_ph  = ph;
        case (ph)
            PH_ADDR: begin
                if (rxb[7:1] == dev_addr) begin
                    dec_ack = 1'b1;
                    if (rxb[0]) dec_rd = 1'b1;
                    else        dec_ph = PH_CMD;
                end else if (rxb == BCAST_WR && mw_en) begin
                    dec_ack = 1'b1;
                    dec_ph  = PH_CMD;
                end else if (rxb[7:1] == ARA_ADDR && rxb[0] && alert_i && alert_pend) begin
                    dec_ack = 1'b1;
                    dec_rd  = 1'b1;
                    dec_ara = 1'b1;
                end
            end
            PH_CMD: begin
                if (int'(rxb) < NREG) begin
                    dec_ack = 1'b1;
                    dec_ph  = PH_DATA;
                end
            end
            default: begin
                dec_ack = 1'b1;
                dec_wr  = !wr_done;
            end
        endcase
    end

    assign dec_fire = ctl_ok && (st == S_RX) && ev.rise && (bitcnt == 4'd7);
    assign wr_en    = dec_fire && dec_wr;
    assign ara_done = ctl_ok && (st == S_TXACK) && ev.fall && ara_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            ph      <= PH_ADDR;
            shreg   <= '0;
            bitcnt  <= '0;
            ack_q   <= 1'b0;
            txm     <= 1'b0;
            ara_q   <= 1'b0;
            wr_done <= 1'b0;
            oe_q    <= 1'b0;
            mack_q  <= 1'b0;
            cmd     <= '0;
            tx_ofs  <= '0;
        end else if (tmo) begin
            st   <= S_IDLE;
            oe_q <= 1'b0;
        end else if (ev.start) begin
            st     <= S_RX;
            ph     <= PH_ADDR;
            bitcnt <= '0;
            oe_q   <= 1'b0;
            txm    <= 1'b0;
            ara_q  <= 1'b0;
        end else if (ev.stop) begin
            st   <= S_IDLE;
            oe_q <= 1'b0;
        end else begin
            case (st)
                S_RX: begin
                    if (ev.rise) begin
                        shreg  <= rxb[6:0];
                        bitcnt <= bitcnt + 4'd1;
                        if (bitcnt == 4'd7) begin
                            st    <= S_RXACK;
                            ack_q <= dec_ack;
                            ph    <= dec_ph;
                            if (ph == PH_ADDR && dec_rd) begin
                                txm    <= 1'b1;
                                ara_q  <= dec_ara;
                                tx_ofs <= '0;
                            end
                            if (ph == PH_CMD && dec_ack) begin
                                cmd     <= rxb[IW-1:0];
                                wr_done <= 1'b0;
                            end
                            if (ph == PH_DATA) wr_done <= 1'b1;
                        end
                    end
                end
                S_RXACK: begin
                    if (ev.fall) begin
                        oe_q <= ack_q;
                        st   <= S_ACKHOLD;
                    end
                end
                S_ACKHOLD: begin
                    if (ev.fall) begin
                        oe_q   <= 1'b0;
                        bitcnt <= '0;
                        if (!ack_q)   st <= S_IGNORE;
                        else if (txm) st <= S_TXLOAD;
                        else          st <= S_RX;
                    end
                end
                S_TXLOAD: begin
                    oe_q   <= ~tx_byte[7];
                    bitcnt <= '0;
                    st     <= S_TX;
                end
                S_TX: begin
                    if (ev.rise) begin
                        bitcnt <= bitcnt + 4'd1;
                    end else if (ev.fall) begin
                        if (bitcnt == 4'd8) begin
                            oe_q <= 1'b0;
                            st   <= S_TXACK;
                        end else begin
                            oe_q <= ~tx_byte[3'd7 - bitcnt[2:0]];
                        end
                    end
                end
                S_TXACK: begin
                    if (ev.rise) begin
                        mack_q <= ~sda_i;
                    end else if (ev.fall) begin
                        if (ara_q || !mack_q) begin
                            st <= S_IGNORE;
                        end else begin
                            tx_ofs <= IW'(wrap_idx(int'(tx_ofs), 1, NREG));
                            st     <= S_TXLOAD;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // alert bookkeeping: a rising alert input arms one response
    always_ff @(posedge clk) begin
        if (rst) begin
            alert_q    <= 1'b0;
            alert_pend <= 1'b0;
        end else begin
            alert_q <= alert_i;
            if (alert_i && !alert_q) alert_pend <= 1'b1;
            else if (ara_done)       alert_pend <= 1'b0;
        end
    end

    assign sda_oe = oe_q;

    p_rise_scl_low_r12: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !$past(scl_i));

    p_quiet_release_r3: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE || st == S_IGNORE) |-> !sda_oe);

    p_stop_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (ev.stop && !tmo) |=> (st == S_IDLE));

    p_tmo_release_r11: assert property (@(posedge clk) disable iff (rst)
        tmo |=> (st == S_IDLE && !sda_oe));

    p_ara_needs_alert_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(ara_q) |-> $past(alert_i));

endmodule

// File: tb/smb_regslave_tb.sv
module smb_regslave_tb;
    localparam int CLK_P  = 10;
    localparam int NREG   = 4;
    localparam int TMO    = 600;
    localparam int Q      = 4;
    localparam int WD_LIM = 150000;
    localparam logic [6:0] DEV = 7'h2A;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic alert = 1'b0;
    logic sda_oe;
    logic sda_bus;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 0;
    bit exp_valid = 0;
    logic exp_oe = 1'b0;
    string cur_req = "R1";
    logic [7:0] mreg [NREG];

    always #(CLK_P/2) clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    smb_regslave #(.NREG(NREG), .CTRL_IDX(0), .CTRL_RST(8'h10), .TMO_CYC(TMO)) u_dut (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus),
        .dev_addr(DEV), .alert_i(alert), .sda_oe(sda_oe));

    // per-clock comparison of the pull-down against the bench's expectation
    always @(posedge clk) begin
        #1;
        if (exp_valid && !done) begin
            checks++;
            if (sda_oe !== exp_oe) begin
                errors++;
                $display("FAIL %s (R12 bit timing) sda_oe=%0b expected %0b at cycle %0d",
                         cur_req, sda_oe, exp_oe, cyc);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == WD_LIM && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WD_LIM);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic put_bit(input logic mb, input logic eoe, output logic s);
        tick(Q);
        sda_m = mb;
        tick(Q);
        scl = 1'b1;
        exp_oe = eoe;
        exp_valid = 1;
        tick(Q);
        s = sda_bus;
        tick(Q);
        exp_valid = 0;
        scl = 1'b0;
    endtask

    task automatic bus_start();
        sda_m = 1'b0;
        tick(2*Q);
        scl = 1'b0;
    endtask

    task automatic bus_rstart();
        tick(Q); sda_m = 1'b1;
        tick(Q); scl = 1'b1;
        tick(Q); sda_m = 1'b0;
        tick(Q); scl = 1'b0;
    endtask

    task automatic bus_stop();
        tick(Q); sda_m = 1'b0;
        tick(Q); scl = 1'b1;
        tick(Q); sda_m = 1'b1;
        tick(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic exp_ack);
        logic s;
        for (int i = 7; i >= 0; i--) put_bit(b[i], 1'b0, s);
        put_bit(1'b1, exp_ack, s);
    endtask

    task automatic recv_byte(input logic [7:0] e, input logic mack, output logic [7:0] got);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            put_bit(1'b1, ~e[i], s);
            got[i] = s;
        end
        put_bit(~mack, 1'b0, s);
    endtask

    task automatic wr_byte(input logic [7:0] c, input logic [7:0] d);
        bus_start();
        send_byte({DEV, 1'b0}, 1'b1);
        send_byte(c, 1'b1);
        send_byte(d, 1'b1);
        bus_stop();
        mreg[c[1:0]] = d;
    endtask

    task automatic rd_byte(input logic [7:0] c, input string tag);
        logic [7:0] g;
        bus_start();
        send_byte({DEV, 1'b0}, 1'b1);
        send_byte(c, 1'b1);
        bus_rstart();
        send_byte({DEV, 1'b1}, 1'b1);
        recv_byte(mreg[c[1:0]], 1'b0, g);
        bus_stop();
        chk(g == mreg[c[1:0]], tag, g, mreg[c[1:0]]);
    endtask

    initial begin
        logic [7:0] g0, g1;
        logic s;
        for (int i = 0; i < NREG; i++) mreg[i] = 8'h00;
        mreg[0] = 8'h10;
        tick(5);
        rst = 1'b0;
        tick(3);

        cur_req = "R1";
        chk(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
        rd_byte(8'd0, "R1 control reset value");
        rd_byte(8'd1, "R1 plain register reset value");

        cur_req = "R4";
        wr_byte(8'd2, 8'hA5);
        cur_req = "R6";
        rd_byte(8'd2, "R6 read byte after R4 write");

        // R5: write word, second byte discarded
        cur_req = "R5";
        bus_start();
        send_byte({DEV, 1'b0}, 1'b1);
        send_byte(8'd1, 1'b1);
        send_byte(8'h3C, 1'b1);
        send_byte(8'h77, 1'b1);
        bus_stop();
        mreg[1] = 8'h3C;

        // R7: read word from 1 returns 1 then 2 (2 still 0xA5 shows R5)
        cur_req = "R7";
        bus_start();
        send_byte({DEV, 1'b0}, 1'b1);
        send_byte(8'd1, 1'b1);
        bus_rstart();
        send_byte({DEV, 1'b1}, 1'b1);
        recv_byte(mreg[1], 1'b1, g0);
        recv_byte(mreg[2], 1'b0, g1);
        bus_stop();
        chk(g0 == mreg[1], "R7 word low byte", g0, mreg[1]);
        chk(g1 == 8'hA5, "R5 second written byte discarded", g1, 8'hA5);

        // R7: wrap from last register to register 0
        wr_byte(8'd3, 8'hC3);
        bus_start();
        send_byte({DEV, 1'b0}, 1'b1);
        send_byte(8'd3, 1'b1);
        bus_rstart();
        send_byte({DEV, 1'b1}, 1'b1);
        recv_byte(mreg[3], 1'b1, g0);
        recv_byte(mreg[0], 1'b0, g1);
        bus_stop();
        chk(g0 == mreg[3], "R7 wrap first byte", g0, mreg[3]);
        chk(g1 == mreg[0], "R7 wrap second byte", g1, mreg[0]);

        // R8: bad command refused, nothing written
        cur_req = "R8";
        bus_start();
        send_byte({DEV, 1'b0}, 1'b1);
        send_byte(8'd7, 1'b0);
        send_byte(8'h99, 1'b0);
        bus_stop();
        rd_byte(8'd3, "R8 register unchanged after refused command");

        // R3: foreign address, following byte must not be driven
        cur_req = "R3";
        bus_start();
        send_byte(8'h40, 1'b0);
        send_byte(8'h00, 1'b0);
        bus_stop();
        chk(sda_oe == 1'b0, "R3 released after mismatch", sda_oe, 0);

        // R9: broadcast write while enabled
        cur_req = "R9";
        bus_start();
        send_byte(8'hC6, 1'b1);
        send_byte(8'd3, 1'b1);
        send_byte(8'h5A, 1'b1);
        bus_stop();
        mreg[3] = 8'h5A;
        rd_byte(8'd3, "R9 broadcast write landed");
        wr_byte(8'd0, 8'h00);
        bus_start();
        send_byte(8'hC6, 1'b0);
        bus_stop();
        rd_byte(8'd3, "R9 broadcast refused when disabled");
        wr_byte(8'd0, 8'h10);

        // R10: alert response
        cur_req = "R10";
        bus_start();
        send_byte(8'h19, 1'b0);
        bus_stop();
        alert = 1'b1;
        tick(3);
        bus_start();
        send_byte(8'h19, 1'b1);
        recv_byte({DEV, 1'b0}, 1'b0, g0);
        bus_stop();
        chk(g0 == {DEV, 1'b0}, "R10 alert response address", g0, {DEV, 1'b0});
        bus_start();
        send_byte(8'h19, 1'b0);
        bus_stop();
        alert = 1'b0;
        tick(2);

        // R11: timeout during a held acknowledge
        cur_req = "R11";
        bus_start();
        for (int i = 7; i >= 0; i--) put_bit(((8'(DEV) << 1) >> i) & 1'b1, 1'b0, s);
        tick(Q + 2);
        chk(sda_oe == 1'b1, "R11 ack held before timeout", sda_oe, 1);
        tick(TMO + 20);
        chk(sda_oe == 1'b0, "R11 released after timeout", sda_oe, 0);
        sda_m = 1'b1;
        tick(Q);
        scl = 1'b1;
        tick(2*Q);
        rd_byte(8'd2, "R11 transaction after timeout");

        cur_req = "R2";
        chk(sda_oe == 1'b0, "R2 idle after stop", sda_oe, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule